// File: doc/BRIEF.md
# Hall-Sensor Six-Step Commutation Decoder

This block turns the three Hall sensor levels of a brushless motor into the phase-input and enable patterns for three half-bridges. Each accepted Hall code selects one of six commutation steps. In that step one leg drives its upper switch, one leg drives its lower switch, and the third leg is switched off. Direction, braking, run/stop and PWM chopping are applied on top of the step.

The Hall lines are asynchronous. They pass through a two-flop synchronizer and a stability filter before a new code is taken. The run, brake, direction and PWM controls are treated as synchronous to `clk_i`. Sensor phasing is fixed at build time by the `PHASE_DEG` parameter (60, 120, 240 or 300):
- 60 and 300 read the middle sensor inverted.
- 240 and 300 swap the meaning of the direction input.

PWM chopping acts on the phase inputs only. While PWM is low, the driven-high leg falls to low and the enables stay on, so the winding current recirculates through the lower switches.

Top module: `hall_commutator`

## Requirements
- R1: After reset, and until a Hall code has first been accepted by the filter, `en_o` and `in_o` are 3'b000.
- R2: With `PHASE_DEG`=120, `dir_i`=1, `run_i`=1, `brake_i`=0 and `pwm_i`=1, the Hall codes map to outputs as follows (leg n on bit n-1; the high leg has both its `in_o` and `en_o` bit at 1, the low leg has `en_o`=1 and `in_o`=0, the off leg has both at 0):

  | `hall_i` | high leg | low leg | `en_o` | `in_o` |
  |---|---|---|---|---|
  | 101 | 1 | 2 | 011 | 001 |
  | 100 | 1 | 3 | 101 | 001 |
  | 110 | 2 | 3 | 110 | 010 |
  | 010 | 2 | 1 | 011 | 010 |
  | 011 | 3 | 1 | 101 | 100 |
  | 001 | 3 | 2 | 110 | 100 |

- R3: With `dir_i`=0 the same steps apply with the high and low legs exchanged: `en_o` is unchanged and `in_o` is `en_o` with the high bit cleared.
- R4: In 120 or 240 phasing, Hall codes 000 and 111 are invalid and give `en_o`=`in_o`=000.
- R5: While `run_i`=0, `en_o` and `in_o` are 000 from the first clock edge after `run_i` is sampled low.
- R6: While `brake_i`=1 (with `run_i`=1), `in_o` is 000 and `en_o` keeps the step's two enabled legs, from the first edge.
- R7: While `pwm_i`=0, `in_o` is 000 and `en_o` keeps the step's two enabled legs, from the first edge.
- R8: A new Hall level must be seen at the synchronizer output for `STABLE_CYCLES` consecutive clocks before it is accepted. A change held at `hall_i` for fewer cycles has no effect. A held change appears at the outputs on the (`STABLE_CYCLES`+3)th rising edge after it.
- R9: With 60 or 300 phasing, the raw code is decoded as the 120-degree code with bit 1 inverted. Codes 010 and 101 are then the invalid ones.
- R10: With 240 or 300 phasing, `dir_i`=1 yields the pattern that R3 gives and `dir_i`=0 the one that R2 gives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hall_i | input | 3 | Raw Hall sensor levels, bit n-1 for sensor n |
| dir_i | input | 1 | Rotation sense select |
| brake_i | input | 1 | Brake: all phase inputs low |
| run_i | input | 1 | Run (1) / stop (0) |
| pwm_i | input | 1 | Chopping signal applied to the high-side phase input |
| in_o | output | 3 | Phase inputs, 1 = upper switch, 0 = lower switch |
| en_o | output | 3 | Leg enables |

## Verification
An error in the accepted Hall code or the step it selects shows as a wrong leg pair on `en_o`/`in_o`. That appears `STABLE_CYCLES`+3 edges after a sensor change, so the bench sweeps every code in both directions and under two phasings. A filter count that is off by one shows as an output change one edge early or late, or as a short glitch that gets through. The bench samples both sides of the expected edge and applies a sub-threshold pulse. Errors in the control gating appear one edge after `run_i`, `brake_i` or `pwm_i` moves.

// File: rtl/hall_pkg.sv
package hall_pkg;
  localparam int unsigned NUM_LEGS = 3;
  localparam int unsigned LEG_W    = 2;

  typedef struct packed {
    logic             ok;
    logic [LEG_W-1:0] hi;
    logic [LEG_W-1:0] lo;
  } step_t;
endpackage

// File: rtl/hall_filter.sv
module hall_filter #(
  parameter int unsigned W      = 3,
  parameter int unsigned STABLE = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] code_o,
  output logic         valid_o
);
  localparam int unsigned CW = $clog2(STABLE + 1);

  logic [W-1:0]  meta_q, sync_q, cand_q, acc_q;
  logic [CW-1:0] cnt_q;
  logic          seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      cand_q <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
      if (sync_q != cand_q) begin
        cand_q <= sync_q;
        cnt_q  <= CW'(1);
      end else if (cnt_q != CW'(STABLE)) begin
        cnt_q <= cnt_q + CW'(1);
        // level seen STABLE cycles in a row
        if (cnt_q == CW'(STABLE - 1)) begin
          acc_q  <= cand_q;
          seen_q <= 1'b1;
        end
      end
    end
  end

  assign code_o  = acc_q;
  assign valid_o = seen_q;
endmodule

// File: rtl/step_decode.sv
module step_decode
  import hall_pkg::*;
#(
  parameter bit SIXTY = 1'b0
) (
  input  logic [2:0] code_i,
  output step_t      step_o
);
  localparam logic [2:0] FLIP = SIXTY ? 3'b010 : 3'b000;

  logic [2:0] norm;
  assign norm = code_i ^ FLIP;

  always_comb begin
    step_o = '{ok: 1'b1, hi: 2'd0, lo: 2'd0};
    unique case (norm)
      3'b101:  begin step_o.hi = 2'd0; step_o.lo = 2'd1; end
      3'b100:  begin step_o.hi = 2'd0; step_o.lo = 2'd2; end
      3'b110:  begin step_o.hi = 2'd1; step_o.lo = 2'd2; end
      3'b010:  begin step_o.hi = 2'd1; step_o.lo = 2'd0; end
      3'b011:  begin step_o.hi = 2'd2; step_o.lo = 2'd0; end
      3'b001:  begin step_o.hi = 2'd2; step_o.lo = 2'd1; end
      default: step_o.ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/leg_drive.sv
module leg_drive
  import hall_pkg::*;
#(
  parameter bit REV = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  step_t               step_i,
  input  logic                valid_i,
  input  logic                run_i,
  input  logic                brake_i,
  input  logic                pwm_i,
  input  logic                dir_i,
  output logic [NUM_LEGS-1:0] in_o,
  output logic [NUM_LEGS-1:0] en_o
);
  logic             fwd, live;
  logic [LEG_W-1:0] hi_leg, lo_leg;
  logic [NUM_LEGS-1:0] in_d, en_d, in_q, en_q;

  assign fwd    = dir_i ^ REV;
  assign hi_leg = fwd ? step_i.hi : step_i.lo;
  assign lo_leg = fwd ? step_i.lo : step_i.hi;
  assign live   = run_i & valid_i & step_i.ok;

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    assign en_d[g] = live & ((hi_leg == LEG_W'(g)) | (lo_leg == LEG_W'(g)));
    assign in_d[g] = live & ~brake_i & pwm_i & (hi_leg == LEG_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q <= '0;
      en_q <= '0;
    end else begin
      in_q <= in_d;
      en_q <= en_d;
    end
  end

  assign in_o = in_q;
  assign en_o = en_q;
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator #(
  parameter int unsigned PHASE_DEG     = 120,
  parameter int unsigned STABLE_CYCLES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] hall_i,
  input  logic       dir_i,
  input  logic       brake_i,
  input  logic       run_i,
  input  logic       pwm_i,
  output logic [2:0] in_o,
  output logic [2:0] en_o
);
  import hall_pkg::*;

  localparam bit SIXTY = (PHASE_DEG == 60) || (PHASE_DEG == 300);
  localparam bit REV   = (PHASE_DEG == 240) || (PHASE_DEG == 300);

  logic [2:0] code;
  logic       code_vld;
  step_t      step;

  hall_filter #(.W(3), .STABLE(STABLE_CYCLES)) u_filt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raw_i   (hall_i),
    .code_o  (code),
    .valid_o (code_vld)
  );

  step_decode #(.SIXTY(SIXTY)) u_dec (
    .code_i (code),
    .step_o (step)
  );

  leg_drive #(.REV(REV)) u_drv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .valid_i (code_vld),
    .run_i   (run_i),
    .brake_i (brake_i),
    .pwm_i   (pwm_i),
    .dir_i   (dir_i),
    .in_o    (in_o),
    .en_o    (en_o)
  );
endmodule

// File: rtl/hall_commutator_chk.sv
module hall_commutator_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       run_i,
  input logic       brake_i,
  input logic       pwm_i,
  input logic [2:0] in_o,
  input logic [2:0] en_o
);
  p_leg_pair_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o == 3'b000) || ($countones(en_o) == 2));

  p_high_enabled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(in_o) && ((in_o & ~en_o) == 3'b000));

  p_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (en_o == 3'b000) && (in_o == 3'b000));

  p_brake_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brake_i |=> in_o == 3'b000);

  p_chop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_i |=> in_o == 3'b000);
endmodule

bind hall_commutator hall_commutator_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .run_i   (run_i),
  .brake_i (brake_i),
  .pwm_i   (pwm_i),
  .in_o    (in_o),
  .en_o    (en_o)
);

// File: tb/sim_hall_commutator.sv
`timescale 1ns/1ps
module sim_hall_commutator;
  localparam int STABLE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hall = 3'b101;
  logic       dir = 1'b1, brake = 1'b0, run = 1'b1, pwm = 1'b1;
  logic [2:0] in0, en0, in1, en1;
  int         errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  hall_commutator #(.PHASE_DEG(120), .STABLE_CYCLES(STABLE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .hall_i(hall), .dir_i(dir), .brake_i(brake),
    .run_i(run), .pwm_i(pwm), .in_o(in0), .en_o(en0));

  hall_commutator #(.PHASE_DEG(300), .STABLE_CYCLES(STABLE)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .hall_i(hall), .dir_i(dir), .brake_i(brake),
    .run_i(run), .pwm_i(pwm), .in_o(in1), .en_o(en1));

  // {in, en} for a 120-degree code, run=1, brake=0, pwm=1
  function automatic logic [5:0] pat(input logic [2:0] c, input logic fwd);
    logic [2:0] i, e;
    case (c)
      3'b101: begin e = 3'b011; i = 3'b001; end
      3'b100: begin e = 3'b101; i = 3'b001; end
      3'b110: begin e = 3'b110; i = 3'b010; end
      3'b010: begin e = 3'b011; i = 3'b010; end
      3'b011: begin e = 3'b101; i = 3'b100; end
      3'b001: begin e = 3'b110; i = 3'b100; end
      default: begin e = 3'b000; i = 3'b000; end
    endcase
    if (!fwd) i = e & ~i;
    return {i, e};
  endfunction

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {in,en} actual=%b_%b expected=%b_%b", tag,
               act[5:3], act[2:0], exp[5:3], exp[2:0]);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_hall(input logic [2:0] h);
    hall = h;
    cyc(STABLE + 4);
  endtask

  task automatic t_reset();
    cyc(2);
    check("R1 u0 before accept", {in0, en0}, 6'b0);
    check("R1 u1 before accept", {in1, en1}, 6'b0);
    cyc(STABLE + 4);
  endtask

  task automatic t_sweep(input logic d);
    logic [2:0] seq [6] = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};
    dir = d;
    for (int k = 0; k < 6; k++) begin
      set_hall(seq[d ? k : 5 - k]);
      check(d ? "R2 forward step" : "R3 reverse step", {in0, en0}, pat(hall, d));
    end
  endtask

  task automatic t_invalid();
    dir = 1'b1;
    set_hall(3'b000);
    check("R4 code 000", {in0, en0}, 6'b0);
    set_hall(3'b111);
    check("R4 code 111", {in0, en0}, 6'b0);
  endtask

  task automatic t_phasing();
    logic [2:0] seq [6] = '{3'b111, 3'b110, 3'b100, 3'b000, 3'b001, 3'b011};
    for (int d = 0; d < 2; d++) begin
      dir = d[0];
      for (int k = 0; k < 6; k++) begin
        set_hall(seq[k]);
        // R9 middle sensor inverted, R10 direction meaning swapped
        check("R9 R10 u1 60-type step", {in1, en1}, pat(hall ^ 3'b010, !dir));
      end
    end
    set_hall(3'b010);
    check("R9 u1 code 010 invalid", {in1, en1}, 6'b0);
    set_hall(3'b101);
    check("R9 u1 code 101 invalid", {in1, en1}, 6'b0);
  endtask

  task automatic t_controls();
    dir = 1'b1;
    set_hall(3'b110);
    run = 1'b0; cyc(1);
    check("R5 run low", {in0, en0}, 6'b0);
    run = 1'b1; cyc(1);
    check("R5 run restored", {in0, en0}, pat(3'b110, 1'b1));
    brake = 1'b1; cyc(1);
    check("R6 brake", {in0, en0}, {3'b000, 3'b110});
    cyc(3);
    check("R6 brake held", {in0, en0}, {3'b000, 3'b110});
    brake = 1'b0; pwm = 1'b0; cyc(1);
    check("R7 pwm low", {in0, en0}, {3'b000, 3'b110});
    pwm = 1'b1; cyc(1);
    check("R7 pwm high", {in0, en0}, pat(3'b110, 1'b1));
    dir = 1'b0; cyc(1);
    check("R3 dir change", {in0, en0}, pat(3'b110, 1'b0));
    dir = 1'b1; cyc(1);
  endtask

  task automatic t_filter();
    dir = 1'b1;
    set_hall(3'b101);
    hall = 3'b100; cyc(STABLE - 1);
    hall = 3'b101; cyc(STABLE + 6);
    check("R8 short pulse ignored", {in0, en0}, pat(3'b101, 1'b1));
    hall = 3'b100; cyc(STABLE + 2);
    check("R8 not before edge", {in0, en0}, pat(3'b101, 1'b1));
    cyc(1);
    check("R8 at latency edge", {in0, en0}, pat(3'b100, 1'b1));
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    t_reset();
    t_sweep(1'b1);
    t_sweep(1'b0);
    t_invalid();
    t_phasing();
    t_controls();
    t_filter();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule